// File: doc/BRIEF.md
# Branch and Loop Condition Evaluator

This unit decides whether a short conditional branch or a counted loop branch is taken. It takes a 5-bit condition selector, five status flags (carry, zero, sign, overflow, parity) and the current count register value. One clock after a request it returns the take decision. For the counted-loop selectors it also returns the decremented count and a write enable for the count register.

The block covers four groups of conditions. Unsigned comparisons use carry and zero. Signed comparisons use sign, overflow and zero. Single-flag tests read one flag. Count-based branches read the count register. Target address arithmetic and flag generation are done elsewhere. The parity flag arrives already reduced over the low 8 bits of the last result.

The selector encoding is part of the behaviour. For flag conditions, bit 4 is 0, bits 3:1 pick a base test, and bit 0 inverts that test. Aliased mnemonics (equal/zero, above/not-below-or-equal, parity/parity-even, and so on) are the same selector value. For count conditions, bit 4 is 1 and bits 3:0 pick the form.

Top module: `cond_eval_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs `res_valid_o`, `take_o`, `cx_we_o` and `cx_next_o` are all cleared to zero at that edge.
- R2: `res_valid_o` is high in the cycle after a cycle where `eval_valid_i` was sampled high. When `res_valid_o` is low, `take_o` and `cx_we_o` are low.
- R3: Unsigned selectors (bits 3:1 give the base test, bit 0 inverts it):
  - 0x02: below, taken when CF=1.
  - 0x03: above-or-equal, taken when CF=0.
  - 0x06: below-or-equal, taken when CF=1 or ZF=1.
  - 0x07: above, taken when CF=0 and ZF=0.
- R4: Signed selectors:
  - 0x0C: less, taken when SF differs from OF.
  - 0x0D: greater-or-equal, taken when SF equals OF.
  - 0x0E: less-or-equal, taken when ZF=1 or SF differs from OF.
  - 0x0F: greater, taken when ZF=0 and SF equals OF.
- R5: Single-flag selectors. Each even selector is taken when its flag is 1, and the next odd selector is taken when that flag is 0:
  - 0x00/0x01: overflow (OF).
  - 0x04/0x05: equal or zero (ZF).
  - 0x08/0x09: sign (SF).
  - 0x0A/0x0B: parity-even (PF).
- R6: Selector 0x13 (count-is-zero) is taken exactly when the count input is 0. It never asserts `cx_we_o`, and `cx_next_o` reads 0.
- R7: Selector 0x12 (plain loop) asserts `cx_we_o`. `cx_next_o` equals the count input minus 1, and the branch is taken when that new value is nonzero.
- R8: Selector 0x11 (loop-while-equal) and selector 0x10 (loop-while-not-equal) write the decremented count the same way as R7. They are taken only when the new count is nonzero and ZF is 1 for 0x11, or ZF is 0 for 0x10.
- R9: A count input of 0 on a loop selector wraps `cx_next_o` to all ones. The branch is then taken, subject to the ZF term of R8.
- R10: Selectors 0x14 through 0x1F are never taken and never assert `cx_we_o`, and `cx_next_o` reads 0.
- R11: Flag selectors 0x00 through 0x0F never assert `cx_we_o`, and `cx_next_o` reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eval_valid_i | input | 1 | Request strobe; the other inputs are sampled with it |
| cond_sel_i | input | 5 | Condition selector |
| cf_i | input | 1 | Carry flag |
| zf_i | input | 1 | Zero flag |
| sf_i | input | 1 | Sign flag |
| of_i | input | 1 | Overflow flag |
| pf_i | input | 1 | Parity flag (low byte, even) |
| cx_i | input | CX_W | Current count register value |
| res_valid_o | output | 1 | Result valid, one cycle after request |
| take_o | output | 1 | Branch taken |
| cx_we_o | output | 1 | Write enable for the count register |
| cx_next_o | output | CX_W | Decremented count when `cx_we_o` is high, else 0 |

## Verification
The bench builds the unit with the default 16-bit count register. All 32 selector values can then be driven together with every combination of the five flags. Random counts almost never land on 0, 1 or all ones, so directed cases drive these values on purpose. This covers the wrap to all ones, a loop whose new count is exactly zero, and a count-is-zero test at both 0 and 1.

// File: rtl/cond_eval_pkg.sv
// Package: selector encoding and flag bundle shared by the condition evaluator.
// Assumes: flag selectors have bit 4 clear and use bit 0 as an inversion.
package cond_eval_pkg;

    typedef enum logic [4:0] {
        SEL_OVF     = 5'h00,
        SEL_NOVF    = 5'h01,
        SEL_BELOW   = 5'h02,
        SEL_AEQ     = 5'h03,
        SEL_EQ      = 5'h04,
        SEL_NEQ     = 5'h05,
        SEL_BEQ     = 5'h06,
        SEL_ABOVE   = 5'h07,
        SEL_NEG     = 5'h08,
        SEL_POS     = 5'h09,
        SEL_PEVEN   = 5'h0A,
        SEL_PODD    = 5'h0B,
        SEL_LESS    = 5'h0C,
        SEL_GEQ     = 5'h0D,
        SEL_LEQ     = 5'h0E,
        SEL_GREATER = 5'h0F,
        SEL_LOOP_NE = 5'h10,
        SEL_LOOP_EQ = 5'h11,
        SEL_LOOP    = 5'h12,
        SEL_CX_ZERO = 5'h13
    } cond_sel_e;

    // Base flag test picked by selector bits 3:1.
    typedef enum logic [2:0] {
        BT_OF    = 3'd0,
        BT_CF    = 3'd1,
        BT_ZF    = 3'd2,
        BT_CF_ZF = 3'd3,
        BT_SF    = 3'd4,
        BT_PF    = 3'd5,
        BT_SLT   = 3'd6,
        BT_SLE   = 3'd7
    } base_test_e;

    // Count-form picked by selector bits 1:0 when bit 4 is set.
    typedef enum logic [1:0] {
        CF_LOOP_NE = 2'd0,
        CF_LOOP_EQ = 2'd1,
        CF_LOOP    = 2'd2,
        CF_CX_ZERO = 2'd3
    } cnt_form_e;

    typedef struct packed {
        logic cf;
        logic zf;
        logic sf;
        logic of;
        logic pf;
    } flags_t;

endpackage

// File: rtl/flag_cond_eval.sv
// Module: flag_cond_eval
// Combinational evaluation of the sixteen flag-based conditions.
// Assumes: the selector is split by the caller into a 3-bit base test and
// an inversion bit; the parity flag is already reduced over the low byte.
module flag_cond_eval
    import cond_eval_pkg::*;
(
    input  flags_t     flags_i,
    input  logic [2:0] base_i,
    input  logic       invert_i,
    output logic       hit_o
);

    logic base_hit;
    logic sign_ne_ovf;

    // Purpose: signed "less" term shared by two base tests.
    always_comb begin
        sign_ne_ovf = flags_i.sf ^ flags_i.of;
    end

    // Purpose: pick the base test named by the selector.
    always_comb begin
        unique case (base_test_e'(base_i))
            BT_OF:    base_hit = flags_i.of;
            BT_CF:    base_hit = flags_i.cf;
            BT_ZF:    base_hit = flags_i.zf;
            BT_CF_ZF: base_hit = flags_i.cf | flags_i.zf;
            BT_SF:    base_hit = flags_i.sf;
            BT_PF:    base_hit = flags_i.pf;
            BT_SLT:   base_hit = sign_ne_ovf;
            BT_SLE:   base_hit = flags_i.zf | sign_ne_ovf;
            default:  base_hit = 1'b0;
        endcase
    end

    // Purpose: apply the complementing bit of the selector.
    always_comb begin
        hit_o = base_hit ^ invert_i;
    end

endmodule

// File: rtl/cx_loop_eval.sv
// Module: cx_loop_eval
// Combinational evaluation of the count-register branch forms.
// Assumes: the loop forms decrement first and test the new value; the
// count-is-zero form tests the entry value and leaves the register alone.
module cx_loop_eval
    import cond_eval_pkg::*;
#(
    parameter int CX_W = 16
) (
    input  logic [CX_W-1:0] cx_i,
    input  logic            zf_i,
    input  logic [1:0]      form_i,
    output logic            take_o,
    output logic            we_o,
    output logic [CX_W-1:0] cx_next_o
);

    localparam logic [CX_W-1:0] CX_ONE  = {{(CX_W-1){1'b0}}, 1'b1};
    localparam logic [CX_W-1:0] CX_ZERO = '0;

    logic [CX_W-1:0] cx_dec;
    logic            dec_nz;
    logic            entry_zero;

    // Purpose: decremented count, wrapping from zero to all ones.
    always_comb begin
        cx_dec     = cx_i - CX_ONE;
        dec_nz     = (cx_dec != CX_ZERO);
        entry_zero = (cx_i == CX_ZERO);
    end

    // Purpose: form-specific take, write enable and next count.
    always_comb begin
        take_o    = 1'b0;
        we_o      = 1'b0;
        cx_next_o = CX_ZERO;
        unique case (cnt_form_e'(form_i))
            CF_LOOP_NE: begin
                we_o      = 1'b1;
                cx_next_o = cx_dec;
                take_o    = dec_nz & ~zf_i;
            end
            CF_LOOP_EQ: begin
                we_o      = 1'b1;
                cx_next_o = cx_dec;
                take_o    = dec_nz & zf_i;
            end
            CF_LOOP: begin
                we_o      = 1'b1;
                cx_next_o = cx_dec;
                take_o    = dec_nz;
            end
            CF_CX_ZERO: begin
                take_o    = entry_zero;
            end
            default: begin
                take_o    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cond_eval_unit.sv
// Module: cond_eval_unit (top)
// Registered branch/loop condition evaluator: one request per cycle, result
// one cycle later. Routes flag selectors to flag_cond_eval and count
// selectors to cx_loop_eval; reserved selectors yield a not-taken result.
// Assumes: inputs are stable around the clock edge where eval_valid_i is high.
module cond_eval_unit
    import cond_eval_pkg::*;
#(
    parameter int CX_W  = 16,
    parameter int SEL_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            eval_valid_i,
    input  logic [SEL_W-1:0] cond_sel_i,
    input  logic            cf_i,
    input  logic            zf_i,
    input  logic            sf_i,
    input  logic            of_i,
    input  logic            pf_i,
    input  logic [CX_W-1:0] cx_i,
    output logic            res_valid_o,
    output logic            take_o,
    output logic            cx_we_o,
    output logic [CX_W-1:0] cx_next_o
);

    localparam int FORM_W = 2;

    flags_t          flags;
    logic            is_count_sel;
    logic            is_reserved;
    logic            flag_hit;
    logic            cnt_take;
    logic            cnt_we;
    logic [CX_W-1:0] cnt_next;
    logic            take_d;
    logic            we_d;
    logic [CX_W-1:0] next_d;

    // Purpose: bundle the flag inputs.
    always_comb begin
        flags = '{cf: cf_i, zf: zf_i, sf: sf_i, of: of_i, pf: pf_i};
    end

    // Purpose: classify the selector into flag, count or reserved space.
    always_comb begin
        is_count_sel = cond_sel_i[SEL_W-1];
        is_reserved  = is_count_sel & (cond_sel_i[SEL_W-2:FORM_W] != '0);
    end

    flag_cond_eval u_flag (
        .flags_i  (flags),
        .base_i   (cond_sel_i[3:1]),
        .invert_i (cond_sel_i[0]),
        .hit_o    (flag_hit)
    );

    cx_loop_eval #(
        .CX_W (CX_W)
    ) u_cnt (
        .cx_i      (cx_i),
        .zf_i      (zf_i),
        .form_i    (cond_sel_i[FORM_W-1:0]),
        .take_o    (cnt_take),
        .we_o      (cnt_we),
        .cx_next_o (cnt_next)
    );

    // Purpose: merge the two evaluators and squash reserved selectors.
    always_comb begin
        if (is_reserved) begin
            take_d = 1'b0;
            we_d   = 1'b0;
            next_d = '0;
        end else if (is_count_sel) begin
            take_d = cnt_take;
            we_d   = cnt_we;
            next_d = cnt_next;
        end else begin
            take_d = flag_hit;
            we_d   = 1'b0;
            next_d = '0;
        end
    end

    // Purpose: result register; outputs are quiet except in a valid cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid_o <= 1'b0;
            take_o      <= 1'b0;
            cx_we_o     <= 1'b0;
            cx_next_o   <= '0;
        end else begin
            res_valid_o <= eval_valid_i;
            take_o      <= eval_valid_i & take_d;
            cx_we_o     <= eval_valid_i & we_d;
            cx_next_o   <= eval_valid_i ? next_d : '0;
        end
    end

    AST_RESULT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        eval_valid_i |=> res_valid_o); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid_o |-> (!take_o && !cx_we_o)); // R2
    AST_CXZ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_valid_i && cond_sel_i == SEL_CX_ZERO) |=> !cx_we_o); // R6
    AST_LOOP_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_valid_i && cond_sel_i == SEL_LOOP) |=> (cx_we_o && cx_next_o == $past(cx_i) - 1'b1)); // R7
    AST_LOOP_TAKE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cx_we_o && take_o) |-> (cx_next_o != '0)); // R8
    AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_valid_i && cond_sel_i[4] && cond_sel_i[3:2] != 2'b00) |=> (!take_o && !cx_we_o)); // R10
    AST_FLAG_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_valid_i && !cond_sel_i[4]) |=> !cx_we_o); // R11

endmodule

// File: tb/cond_eval_unit_tb.sv
// Bench: directed corners plus seeded random requests, checked against
// an independent reference model written from the requirements.
module cond_eval_unit_tb;

    localparam int CXW = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           eval_valid = 1'b0;
    logic [4:0]     sel = '0;
    logic           cf = 0, zf = 0, sf = 0, of_f = 0, pf = 0;
    logic [CXW-1:0] cx = '0;
    logic           res_valid, take, cx_we;
    logic [CXW-1:0] cx_next;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk; // 125 MHz

    cond_eval_unit #(.CX_W(CXW)) u_dut (
        .clk (clk), .rst_n (rst_n), .eval_valid_i (eval_valid),
        .cond_sel_i (sel), .cf_i (cf), .zf_i (zf), .sf_i (sf), .of_i (of_f),
        .pf_i (pf), .cx_i (cx), .res_valid_o (res_valid), .take_o (take),
        .cx_we_o (cx_we), .cx_next_o (cx_next)
    );

    function automatic string req_of(logic [4:0] c);
        if (!c[4]) begin
            case (c[3:1])
                3'd1, 3'd3: return "R3";
                3'd6, 3'd7: return "R4";
                default:    return "R5";
            endcase
        end
        if (c[3:2] != 2'b00) return "R10";
        if (c[1:0] == 2'd3)  return "R6";
        if (c[1:0] == 2'd2)  return "R7";
        return "R8";
    endfunction

    // Reference: {take, we, next}
    function automatic logic [CXW+1:0] ref_eval(logic [4:0] c, logic fc, logic fz,
                                                logic fs, logic fo, logic fp,
                                                logic [CXW-1:0] v);
        logic t;
        logic [CXW-1:0] n;
        if (!c[4]) begin
            case (c[3:1])
                3'd0: t = fo;
                3'd1: t = fc;
                3'd2: t = fz;
                3'd3: t = fc | fz;
                3'd4: t = fs;
                3'd5: t = fp;
                3'd6: t = fs != fo;
                default: t = fz | (fs != fo);
            endcase
            return {t ^ c[0], 1'b0, {CXW{1'b0}}};
        end
        if (c[3:2] != 2'b00) return '0;
        if (c[1:0] == 2'd3) return {v == 0, 1'b0, {CXW{1'b0}}};
        n = v - 1;
        case (c[1:0])
            2'd2:    t = (n != 0);
            2'd1:    t = (n != 0) && fz;
            default: t = (n != 0) && !fz;
        endcase
        return {t, 1'b1, n};
    endfunction

    task automatic check(string req, string what, logic [CXW-1:0] act, logic [CXW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_one(logic [4:0] c, logic fc, logic fz, logic fs, logic fo,
                           logic fp, logic [CXW-1:0] v);
        logic [CXW+1:0] e;
        string r;
        sel = c; cf = fc; zf = fz; sf = fs; of_f = fo; pf = fp; cx = v;
        eval_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        e = ref_eval(c, fc, fz, fs, fo, fp, v);
        r = req_of(c);
        if (c[4] && c[1:0] != 2'd3 && c[3:2] == 2'b00 && v == 0) r = "R9";
        if (!c[4]) r = {r, "/R11"};
        check("R2", "valid", {15'd0, res_valid}, 16'd1);
        check(r, "take", {15'd0, take}, {15'd0, e[CXW+1]});
        check(r, "we", {15'd0, cx_we}, {15'd0, e[CXW]});
        check(r, "cx_next", cx_next, e[CXW-1:0]);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0C0D));
        eval_valid = 1'b1; sel = 5'h12; cx = 16'h0005;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset clears everything even with a request pending
        check("R1", "valid", {15'd0, res_valid}, 16'd0);
        check("R1", "take", {15'd0, take}, 16'd0);
        check("R1", "we", {15'd0, cx_we}, 16'd0);
        check("R1", "cx_next", cx_next, 16'd0);
        eval_valid = 1'b0;
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);

        // Directed: every flag selector across all flag combinations (R3 R4 R5 R11)
        for (int c = 0; c < 16; c++)
            for (int f = 0; f < 32; f++)
                run_one(c[4:0], f[4], f[3], f[2], f[1], f[0], 16'h1234);
        // Count corners: R6 R7 R8 R9
        for (int c = 16; c < 20; c++)
            for (int z = 0; z < 2; z++) begin
                run_one(c[4:0], 1'b0, z[0], 1'b0, 1'b0, 1'b0, 16'h0000);
                run_one(c[4:0], 1'b0, z[0], 1'b0, 1'b0, 1'b0, 16'h0001);
                run_one(c[4:0], 1'b0, z[0], 1'b0, 1'b0, 1'b0, 16'h0002);
                run_one(c[4:0], 1'b0, z[0], 1'b0, 1'b0, 1'b0, 16'hFFFF);
            end
        // Reserved selectors: R10
        for (int c = 20; c < 32; c++)
            run_one(c[4:0], 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0003);

        // Idle after a taken loop: R2
        run_one(5'h12, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0009);
        eval_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R2", "idle valid", {15'd0, res_valid}, 16'd0);
        check("R2", "idle take", {15'd0, take}, 16'd0);
        check("R2", "idle we", {15'd0, cx_we}, 16'd0);

        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic [4:0] rc;
            logic [CXW-1:0] rv;
            rc = 5'($urandom_range(0, 31));
            rv = ($urandom_range(0, 3) == 0) ? CXW'($urandom_range(0, 2)) : CXW'($urandom);
            run_one(rc, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom), rv);
        end
        eval_valid = 1'b0;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule